// File: doc/BRIEF.md
# Memory Error Status and Capture Registers

This block is the error-reporting register bank of a DRAM controller. A DRAM ECC checker and the controller's housekeeping logic send it single-cycle event pulses: correctable ECC error, uncorrectable ECC error, refresh timeout, locked access to non-DRAM memory, and thermal sensor event. Along with the ECC events, the checker presents the failing physical address, the channel it came from and the 8-bit ECC syndrome.

Each event sets a sticky flag in a 16-bit status register. Software clears a flag by writing a one to its bit. On selected events the block also captures the failing address, channel and syndrome into log registers. An uncorrectable error takes precedence over a correctable one that is already logged. A 16-bit command register selects which flags drive the registered system-error output. All registers are reached through a simple port: a select code, a write strobe, write data, and combinational read data.

Top module: `mem_err_log`

## Requirements
- R1: After reset, every register reads zero and `serr_out` is low.
- R2: Each event sets its own status bit: correctable at bit 0, uncorrectable at bit 1, refresh timeout at bit 8, lock at bit 9, thermal at bit 11. All other status bits read zero. The status register is at select code 0.
- R3: Writing the status register (select 0) clears every error bit that is written as 1. Bits written as 0 keep their value.
- R4: An event in the same cycle as a write that clears its flag leaves the flag set.
- R5: A correctable error captures its log when no error flag (mask 0x0B03) is set at the start of that cycle. The address pointer (select 2) then holds address bits 31:7 in bits 31:7, zeros in bits 6:1 and the channel in bit 0. The extended pointer (select 3) holds address bit 32 in bit 0. The syndrome register (select 4) holds the syndrome.
- R6: A correctable error that arrives while any error flag is set leaves all three log registers unchanged.
- R7: An uncorrectable error that arrives while the uncorrectable flag is clear captures its address, channel and syndrome, even over a logged correctable error. This also holds when a correctable error occurs in the same cycle.
- R8: An uncorrectable error that arrives while the uncorrectable flag is already set leaves the log unchanged.
- R9: Once all error flags have been cleared, the next correctable error is captured again.
- R10: The command register (select 1) stores only the bits in mask 0x0B03. All other bits read zero.
- R11: `serr_out` goes high one clock after any status bit and its command bit are both set. It goes low one clock after no such pair remains.
- R12: Writes to select codes 2, 3 and 4 have no effect. Select codes 5 to 7 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ev_ce | input | 1 | Correctable ECC error pulse |
| ev_ue | input | 1 | Uncorrectable ECC error pulse |
| ev_rto | input | 1 | Refresh timeout pulse |
| ev_lock | input | 1 | Locked access to non-DRAM memory pulse |
| ev_therm | input | 1 | Thermal sensor event pulse |
| err_addr | input | ADDR_W (33) | Failing physical address |
| err_chan | input | 1 | Failing channel |
| err_syn | input | SYN_W (8) | ECC syndrome of the failing access |
| reg_sel | input | 3 | Register select code |
| reg_we | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Read data of the selected register |
| serr_out | output | 1 | Registered system-error output |

## Verification
The hardest situations to reach are the ones where several things meet in a single cycle:
- a correctable and an uncorrectable error together;
- an event together with the write that clears its flag;
- a correctable error while only a non-ECC flag, such as refresh timeout, holds logging blocked.

The bench drives these combinations on purpose, one cycle at a time. After every clock, a behavioural model in the bench is compared with `serr_out` and with every register, read through all eight select codes. A wrong capture priority or a lost event therefore shows up in the very cycle it occurs.

// File: rtl/mel_pkg.sv
package mel_pkg;
  localparam int STS_W = 16;
  localparam logic [STS_W-1:0] ERR_MASK = 16'h0B03;
  localparam int B_CE    = 0;
  localparam int B_UE    = 1;
  localparam int B_RTO   = 8;
  localparam int B_LOCK  = 9;
  localparam int B_THERM = 11;

  typedef enum logic [2:0] {
    SEL_STATUS = 3'd0,
    SEL_CMD    = 3'd1,
    SEL_PTR    = 3'd2,
    SEL_EXT    = 3'd3,
    SEL_SYN    = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic therm;
    logic lock;
    logic rto;
    logic ue;
    logic ce;
  } err_ev_t;

  // place event pulses at their status bit positions
  function automatic logic [STS_W-1:0] ev_to_bits(err_ev_t e);
    logic [STS_W-1:0] b;
    b = '0;
    b[B_CE]    = e.ce;
    b[B_UE]    = e.ue;
    b[B_RTO]   = e.rto;
    b[B_LOCK]  = e.lock;
    b[B_THERM] = e.therm;
    return b;
  endfunction

  // sticky flag update: clear by ones, then set from events (events win)
  function automatic logic [STS_W-1:0] w1c_next(logic [STS_W-1:0] cur,
                                                logic [STS_W-1:0] clr,
                                                logic [STS_W-1:0] set);
    return ((cur & ~clr) | set) & ERR_MASK;
  endfunction
endpackage

// File: rtl/mel_status.sv
module mel_status
  import mel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  err_ev_t          ev,
  input  logic             clr_we,
  input  logic [STS_W-1:0] clr_data,
  output logic [STS_W-1:0] status,
  output logic             any_err,
  output logic             ue_set
);
  logic [STS_W-1:0] ev_bits;
  logic [STS_W-1:0] clr_eff;

  assign ev_bits = ev_to_bits(ev);
  assign clr_eff = clr_we ? (clr_data & ERR_MASK) : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) status <= '0;
    else        status <= w1c_next(status, clr_eff, ev_bits);
  end

  assign any_err = |(status & ERR_MASK);
  assign ue_set  = status[B_UE];

  AST_EVENT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_bits != '0) |=> ((status & $past(ev_bits)) == $past(ev_bits))); // R4

  AST_ONES_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_eff != '0) |=> ((status & $past(clr_eff & ~ev_bits)) == '0)); // R3

  AST_ZEROS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    clr_we |=> ((status & $past(status & ~clr_eff)) == $past(status & ~clr_eff))); // R3
endmodule

// File: rtl/mel_capture.sv
module mel_capture #(
  parameter int ADDR_W    = 33,
  parameter int GRAIN_LSB = 7,
  parameter int SYN_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ce,
  input  logic              ev_ue,
  input  logic              any_err,
  input  logic              ue_set,
  input  logic [ADDR_W-1:0] addr,
  input  logic              chan,
  input  logic [SYN_W-1:0]  syn,
  output logic [31:0]       ptr,
  output logic [7:0]        ext,
  output logic [SYN_W-1:0]  syn_q
);
  localparam int EXT_W = ADDR_W - 32;

  function automatic logic [31:0] pack_ptr(logic [ADDR_W-1:0] a, logic c);
    logic [31:0] p;
    p = '0;
    p[31:GRAIN_LSB] = a[31:GRAIN_LSB];
    p[0] = c;
    return p;
  endfunction

  function automatic logic [7:0] pack_ext(logic [ADDR_W-1:0] a);
    logic [7:0] e;
    e = '0;
    for (int i = 0; i < EXT_W; i++) e[i] = a[32+i];
    return e;
  endfunction

  logic take_ue, take_ce, cap_en;
  assign take_ue = ev_ue && !ue_set;
  assign take_ce = ev_ce && !ev_ue && !any_err;
  assign cap_en  = take_ue || take_ce;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr   <= '0;
      ext   <= '0;
      syn_q <= '0;
    end else if (cap_en) begin
      ptr   <= pack_ptr(addr, chan);
      ext   <= pack_ext(addr);
      syn_q <= syn;
    end
  end

  AST_CE_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ce && !ev_ue && any_err) |=> ($stable(ptr) && $stable(ext) && $stable(syn_q))); // R6

  AST_UE_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_ue && !ue_set) |=> (ptr[31:GRAIN_LSB] == $past(addr[31:GRAIN_LSB]) && syn_q == $past(syn))); // R7

  AST_UE_FIRST_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (ue_set && !ev_ce) |=> ($stable(ptr) && $stable(syn_q))); // R8

  AST_PTR_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ptr[GRAIN_LSB-1:1] == '0); // R5
endmodule

// File: rtl/mel_serr.sv
module mel_serr
  import mel_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [STS_W-1:0] status,
  input  logic [STS_W-1:0] cmd,
  output logic             serr
);
  logic hit;
  assign hit = |(status & cmd & ERR_MASK);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) serr <= 1'b0;
    else        serr <= hit;
  end

  AST_SERR_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(serr) |-> $past((status & cmd) != '0)); // R11

  AST_SERR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & cmd) == '0) |=> !serr); // R11
endmodule

// File: rtl/mem_err_log.sv
module mem_err_log
  import mel_pkg::*;
#(
  parameter int ADDR_W    = 33,
  parameter int GRAIN_LSB = 7,
  parameter int SYN_W     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ev_ce,
  input  logic              ev_ue,
  input  logic              ev_rto,
  input  logic              ev_lock,
  input  logic              ev_therm,
  input  logic [ADDR_W-1:0] err_addr,
  input  logic              err_chan,
  input  logic [SYN_W-1:0]  err_syn,
  input  logic [2:0]        reg_sel,
  input  logic              reg_we,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              serr_out
);
  err_ev_t          ev;
  logic [STS_W-1:0] status, cmd_q;
  logic             any_err, ue_set;
  logic [31:0]      ptr;
  logic [7:0]       ext;
  logic [SYN_W-1:0] syn_q;
  logic             wr_status, wr_cmd;

  assign ev = '{therm: ev_therm, lock: ev_lock, rto: ev_rto, ue: ev_ue, ce: ev_ce};
  assign wr_status = reg_we && (reg_sel == SEL_STATUS);
  assign wr_cmd    = reg_we && (reg_sel == SEL_CMD);

  mel_status u_status (
    .clk(clk), .rst_n(rst_n), .ev(ev), .clr_we(wr_status),
    .clr_data(reg_wdata[STS_W-1:0]), .status(status),
    .any_err(any_err), .ue_set(ue_set)
  );

  mel_capture #(.ADDR_W(ADDR_W), .GRAIN_LSB(GRAIN_LSB), .SYN_W(SYN_W)) u_capture (
    .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue),
    .any_err(any_err), .ue_set(ue_set), .addr(err_addr), .chan(err_chan),
    .syn(err_syn), .ptr(ptr), .ext(ext), .syn_q(syn_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cmd_q <= '0;
    else if (wr_cmd) cmd_q <= reg_wdata[STS_W-1:0] & ERR_MASK;
  end

  mel_serr u_serr (
    .clk(clk), .rst_n(rst_n), .status(status), .cmd(cmd_q), .serr(serr_out)
  );

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_STATUS: reg_rdata[STS_W-1:0] = status;
      SEL_CMD:    reg_rdata[STS_W-1:0] = cmd_q;
      SEL_PTR:    reg_rdata = ptr;
      SEL_EXT:    reg_rdata[7:0] = ext;
      SEL_SYN:    reg_rdata[SYN_W-1:0] = syn_q;
      default:    reg_rdata = '0;
    endcase
  end

  AST_LOG_READ_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && !ev_ce && !ev_ue) |=> ($stable(ptr) && $stable(ext) && $stable(syn_q))); // R12

  AST_CMD_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    wr_cmd |=> ((cmd_q & ~ERR_MASK) == '0)); // R10

  AST_RSVD_STATUS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_sel == SEL_STATUS) |-> (reg_rdata[31:12] == '0 && reg_rdata[10] == 1'b0
                                 && reg_rdata[7:2] == '0)); // R2
endmodule

// File: tb/tb_mem_err_log.sv
module tb_mem_err_log;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ev_ce = 0, ev_ue = 0, ev_rto = 0, ev_lock = 0, ev_therm = 0;
  logic [32:0] err_addr = '0;
  logic        err_chan = 0;
  logic [7:0]  err_syn = '0;
  logic [2:0]  reg_sel = '0;
  logic        reg_we = 0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        serr_out;

  int n_checks = 0;
  int n_fail = 0;

  // behavioural reference state
  logic [15:0] m_st = '0, m_cmd = '0;
  logic [31:0] m_ptr = '0;
  logic [7:0]  m_ext = '0, m_syn = '0;
  logic        m_serr = 0;

  mem_err_log dut (
    .clk(clk), .rst_n(rst_n), .ev_ce(ev_ce), .ev_ue(ev_ue), .ev_rto(ev_rto),
    .ev_lock(ev_lock), .ev_therm(ev_therm), .err_addr(err_addr),
    .err_chan(err_chan), .err_syn(err_syn), .reg_sel(reg_sel), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .serr_out(serr_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] exp_rd(int sel);
    case (sel)
      0: return {16'h0, m_st};
      1: return {16'h0, m_cmd};
      2: return m_ptr;
      3: return {24'h0, m_ext};
      4: return {24'h0, m_syn};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic sweep(string tag);
    for (int s = 0; s < 8; s++) begin
      reg_sel = s[2:0];
      #1;
      chk(tag, $sformatf("sel %0d", s), reg_rdata, exp_rd(s));
    end
    chk(tag, "serr_out", {31'h0, serr_out}, {31'h0, m_serr});
  endtask

  // ev = {therm, lock, rto, ue, ce}
  task automatic cyc(string tag, logic [4:0] ev, logic [32:0] a, logic ch,
                     logic [7:0] sy, logic we, int sel, logic [31:0] wd);
    logic [15:0] evb, clr;
    logic        any, ue_old, nserr;
    {ev_therm, ev_lock, ev_rto, ev_ue, ev_ce} = ev;
    err_addr = a; err_chan = ch; err_syn = sy;
    reg_we = we; reg_sel = sel[2:0]; reg_wdata = wd;
    @(posedge clk);
    // model: everything from pre-edge state
    evb = 16'h0;
    if (ev[0]) evb = evb | 16'h0001;
    if (ev[1]) evb = evb | 16'h0002;
    if (ev[2]) evb = evb | 16'h0100;
    if (ev[3]) evb = evb | 16'h0200;
    if (ev[4]) evb = evb | 16'h0800;
    any = (m_st & 16'h0B03) != 0;
    ue_old = m_st[1];
    nserr = (m_st & m_cmd) != 0;
    clr = (we && sel == 0) ? wd[15:0] : 16'h0;
    if ((ev[1] && !ue_old) || (ev[0] && !ev[1] && !any)) begin
      m_ptr = (a[31:0] & 32'hFFFF_FF80) | {31'h0, ch};
      m_ext = {7'h0, a[32]};
      m_syn = sy;
    end
    m_st = ((m_st & ~clr) | evb) & 16'h0B03;
    if (we && sel == 1) m_cmd = wd[15:0] & 16'h0B03;
    m_serr = nserr;
    #1;
    {ev_therm, ev_lock, ev_rto, ev_ue, ev_ce} = 5'b0;
    reg_we = 0;
    sweep(tag);
  endtask

  task automatic idle(string tag);
    cyc(tag, 5'b0, 33'h0, 0, 8'h0, 0, 0, 32'h0);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    sweep("R1");
    idle("R1");

    // R2: each source alone
    for (int i = 0; i < 5; i++) begin
      cyc("R2", 5'b1 << i, 33'h0, 0, 8'h0, 0, 0, 32'h0);
      cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'hFFFF_FFFF);
    end

    // R5: first correctable error is logged
    cyc("R5", 5'b00001, 33'h1_2345_67FF, 1, 8'h5A, 0, 0, 0);
    // R6: further correctable error ignored while flag set
    cyc("R6", 5'b00001, 33'h0_ABCD_EF00, 0, 8'h33, 0, 0, 0);
    // R7: uncorrectable overwrites the correctable log
    cyc("R7", 5'b00010, 33'h0_0F0F_0F80, 1, 8'hC3, 0, 0, 0);
    // R8: second uncorrectable does not overwrite
    cyc("R8", 5'b00010, 33'h1_FFFF_FFFF, 0, 8'h11, 0, 0, 0);
    // R3: write zero leaves flags, write one clears only that flag
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'h0);
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'h1);
    // R6: uncorrectable flag still set blocks correctable capture
    cyc("R6", 5'b00001, 33'h0_1111_1100, 0, 8'h22, 0, 0, 0);
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'h0B03);
    // R9: re-armed
    cyc("R9", 5'b00001, 33'h0_7654_3210, 0, 8'h99, 0, 0, 0);
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'hFFFF);

    // R6: refresh-timeout flag alone blocks correctable capture
    cyc("R6", 5'b00100, 33'h0, 0, 8'h0, 0, 0, 0);
    cyc("R6", 5'b00001, 33'h1_0000_0080, 1, 8'h44, 0, 0, 0);
    cyc("R7", 5'b00011, 33'h1_2222_2280, 0, 8'h77, 0, 0, 0);
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'hFFFF);

    // R4: event and clear in the same cycle
    cyc("R4", 5'b00001, 33'h0_0000_0100, 0, 8'h01, 0, 0, 0);
    cyc("R4", 5'b00001, 33'h0_0000_0200, 1, 8'h02, 1, 0, 32'h1);
    cyc("R4", 5'b01000, 33'h0, 0, 8'h0, 1, 0, 32'h0B03);
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'h0B03);

    // R7: simultaneous CE and UE with nothing logged
    cyc("R7", 5'b00011, 33'h0_3333_3380, 1, 8'hE1, 0, 0, 0);
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'h0B03);

    // R10: command register masking
    cyc("R10", 5'b0, 33'h0, 0, 8'h0, 1, 1, 32'hFFFF_FFFF);
    cyc("R10", 5'b0, 33'h0, 0, 8'h0, 1, 1, 32'h0000_0100);

    // R11: system error follows enabled flag with one cycle of delay
    cyc("R11", 5'b00001, 33'h0, 0, 8'h0, 0, 0, 0);
    idle("R11");
    cyc("R11", 5'b00100, 33'h0, 0, 8'h0, 0, 0, 0);
    idle("R11");
    cyc("R11", 5'b0, 33'h0, 0, 8'h0, 1, 1, 32'h0);
    idle("R11");
    cyc("R11", 5'b0, 33'h0, 0, 8'h0, 1, 1, 32'h0800);
    cyc("R11", 5'b10000, 33'h0, 0, 8'h0, 0, 0, 0);
    cyc("R11", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'h0800);
    idle("R11");
    cyc("R3", 5'b0, 33'h0, 0, 8'h0, 1, 0, 32'h0B03);

    // R12: log registers ignore writes, unused selects read zero
    cyc("R12", 5'b0, 33'h0, 0, 8'h0, 1, 2, 32'hFFFF_FFFF);
    cyc("R12", 5'b0, 33'h0, 0, 8'h0, 1, 3, 32'hFFFF_FFFF);
    cyc("R12", 5'b0, 33'h0, 0, 8'h0, 1, 4, 32'hFFFF_FFFF);
    cyc("R12", 5'b0, 33'h0, 0, 8'h0, 1, 6, 32'hFFFF_FFFF);
    idle("R12");

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule